// File: doc/BRIEF.md
# Receive Frame Filter and Acknowledge Decision

This block sits behind a PHY-side deframer and watches a byte-wide stream of received IEEE 802.15.4 MAC frames. A start strobe marks a frame whose PHY header was accepted. The frame bytes then arrive with a valid strobe and a last strobe, and the FCS verdict arrives together with the last byte. The block parses the frame control field and the destination addressing fields as they stream past. It compares them on the fly against the node's programmed PAN ID, short address and 64-bit extended address. From this it raises single-cycle events for frame start, frame end and address match, and keeps a CRC-valid status bit.

At frame end the block also decides whether an automatic acknowledgement should be sent, and signals that decision with a one-cycle request pulse. A transmitter elsewhere builds the acknowledgement. The decision depends on several things: the FCS result, the address match, the frame's acknowledge-request flag, its frame type, whether the destination was the broadcast short address, a 2-bit policy on the frame version number, and a global acknowledge-disable input. The block has two modes. In filtering mode only frames with a good FCS and a matching address are reported as ended. In promiscuous mode every frame that passes the basic type check is reported as ended, even with a bad FCS, and software consults the CRC-valid bit to discard damaged ones.

Top module: `rx_frame_filter`

## Requirements
- R1: One clock after `phr_ok` is sampled high, `ev_rx_start` pulses and a new frame begins at byte index 0. Bytes are accepted only while a frame is open.
- R2: The frame control field is bytes 0 (bits 7:0) and 1 (bits 15:8). Its fields are:
  - bits 2:0: frame type (2 = acknowledgement, 4 to 7 reserved)
  - bit 5: acknowledge request
  - bits 11:10: destination addressing mode (2 = short, 3 = extended)
  - bits 13:12: frame version

  A frame that ends before byte 1, or that carries a reserved frame type, raises no end event, no address match and no acknowledge request in either mode.
- R3: `crc_valid` resets to 0. It takes the frame's `fcs_good` value in the same cycle as every `ev_rx_end` pulse, and holds its value at all other times.
- R4: With `cfg_promisc` = 1, `ev_rx_end` pulses one clock after the last byte of every frame that passes R2, whatever its FCS or address.
- R5: With `cfg_promisc` = 0, `ev_rx_end` pulses only for frames with `fcs_good` = 1 that also raised an address match.
- R6: Byte 2 is the sequence number, bytes 3 and 4 are the destination PAN ID (low byte first), and the destination address starts at byte 5. The destination address is 2 bytes in short mode and 8 bytes (least significant first) in extended mode. A match requires both of the following:
  - the PAN ID equals `cfg_pan_id` or 0xFFFF;
  - the address equals `cfg_short_addr` or 0xFFFF (short mode), or equals `cfg_ext_addr` (extended mode).

  `ev_addr_match` pulses one clock after the final destination address byte, in both modes.
- R7: A frame that ends before its destination address is complete raises neither `ev_addr_match` nor `ack_req`.
- R8: `ack_req` pulses one clock after the last byte, and only when all of the following hold:
  - `fcs_good` = 1;
  - the address matched;
  - the acknowledge-request bit is 1;
  - the frame type is not 2;
  - the destination short address is not 0xFFFF.
- R9: `cfg_ack_off` = 1 suppresses `ack_req` for every frame.
- R10: `cfg_ver_policy` limits which frame versions are acknowledged:

  | Policy | Versions acknowledged |
  |---|---|
  | 0 | version 0 only |
  | 1 | versions up to 1 |
  | 2 | versions up to 2 |
  | 3 | every version |

- R11: Bytes presented while no frame is open are ignored: they produce no event and no acknowledge request.
- R12: All outputs are 0 after reset, and `ev_rx_start`, `ev_rx_end`, `ev_addr_match` and `ack_req` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_short_addr | input | 16 | Node short address |
| cfg_pan_id | input | 16 | Node PAN ID |
| cfg_ext_addr | input | 64 | Node extended address |
| cfg_promisc | input | 1 | 1 selects promiscuous mode |
| cfg_ack_off | input | 1 | 1 suppresses all acknowledge requests |
| cfg_ver_policy | input | 2 | Frame-version acknowledge policy |
| phr_ok | input | 1 | Valid PHY header, opens a frame |
| rx_byte | input | 8 | Received frame byte |
| rx_valid | input | 1 | `rx_byte` is valid this cycle |
| rx_last | input | 1 | Current byte is the last of the frame |
| fcs_good | input | 1 | FCS verdict, qualified by `rx_last` |
| ev_rx_start | output | 1 | Frame start pulse |
| ev_rx_end | output | 1 | Frame end pulse |
| ev_addr_match | output | 1 | Destination address match pulse |
| crc_valid | output | 1 | FCS result of the last reported frame |
| ack_req | output | 1 | Acknowledge request pulse |

## Verification
The assertions take four things for granted about the inputs:
- `fcs_good` only carries meaning together with `rx_valid` and `rx_last`;
- the configuration inputs stay steady while a frame is open;
- a new `phr_ok` does not arrive before a frame has had time to deliver its destination address;
- as a consequence, address matches can never occur on adjacent cycles.

The directed stimulus keeps within these limits. It changes configuration only between frames. It raises `phr_ok` only with the byte path idle. It drives `fcs_good` solely with the last byte, and it returns all strobes to zero after each frame.

// File: rtl/rx_frame_filter.sv
module rx_frame_filter #(
  parameter int IDX_W = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_short_addr,
  input  logic [15:0] cfg_pan_id,
  input  logic [63:0] cfg_ext_addr,
  input  logic        cfg_promisc,
  input  logic        cfg_ack_off,
  input  logic [1:0]  cfg_ver_policy,
  input  logic        phr_ok,
  input  logic [7:0]  rx_byte,
  input  logic        rx_valid,
  input  logic        rx_last,
  input  logic        fcs_good,
  output logic        ev_rx_start,
  output logic        ev_rx_end,
  output logic        ev_addr_match,
  output logic        crc_valid,
  output logic        ack_req
);

  localparam logic [IDX_W-1:0] IX_FCF_LO  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IX_FCF_HI  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_PAN_LO  = IDX_W'(3);
  localparam logic [IDX_W-1:0] IX_PAN_HI  = IDX_W'(4);
  localparam logic [IDX_W-1:0] IX_DST     = IDX_W'(5);
  localparam logic [IDX_W-1:0] IX_S_LAST  = IDX_W'(6);
  localparam logic [IDX_W-1:0] IX_E_LAST  = IDX_W'(12);
  localparam logic [IDX_W-1:0] IX_SAT     = {IDX_W{1'b1}};
  localparam logic [2:0]       TYPE_ACK   = 3'd2;
  localparam logic [2:0]       TYPE_RSVD  = 3'd4;
  localparam logic [1:0]       DM_SHORT   = 2'd2;
  localparam logic [1:0]       DM_EXT     = 2'd3;

  logic             in_frame;
  logic [IDX_W-1:0] idx;
  logic [15:0]      fcf;
  logic             pan_node, pan_bc, a_node, a_bc, hit, bcast;

  logic             take, is_short, is_ext, in_pan, in_dst, dst_done;
  logic             match_now, hit_f, bc_f, second_ok, ver_ok;
  logic             end_fire, ack_fire;
  logic [15:0]      fcf_n;
  logic [IDX_W-1:0] last_dst;
  logic [7:0]       pan_b, node_b;
  logic [63:0]      ext_sh;
  logic             pan_node_n, pan_bc_n, a_node_n, a_bc_n;

  assign take     = rx_valid & in_frame;
  assign fcf_n    = {(idx == IX_FCF_HI) ? rx_byte : fcf[15:8],
                     (idx == IX_FCF_LO) ? rx_byte : fcf[7:0]};
  assign is_short = (fcf[11:10] == DM_SHORT);
  assign is_ext   = (fcf[11:10] == DM_EXT);
  assign last_dst = is_ext ? IX_E_LAST : IX_S_LAST;

  assign in_pan   = (idx == IX_PAN_LO) || (idx == IX_PAN_HI);
  assign pan_b    = (idx == IX_PAN_LO) ? cfg_pan_id[7:0] : cfg_pan_id[15:8];
  assign in_dst   = (is_short | is_ext) && (idx >= IX_DST) && (idx <= last_dst);
  assign ext_sh   = cfg_ext_addr >> {idx - IX_DST, 3'b000};
  assign node_b   = is_short ? ((idx == IX_DST) ? cfg_short_addr[7:0] : cfg_short_addr[15:8])
                             : ext_sh[7:0];

  assign pan_node_n = pan_node & (rx_byte == pan_b);
  assign pan_bc_n   = pan_bc   & (rx_byte == 8'hFF);
  assign a_node_n   = a_node   & (rx_byte == node_b);
  assign a_bc_n     = a_bc     & (rx_byte == 8'hFF);

  assign dst_done  = take && in_dst && (idx == last_dst) && (fcf[2:0] < TYPE_RSVD);
  assign match_now = dst_done && (pan_node | pan_bc) && (a_node_n | (is_short & a_bc_n));
  assign hit_f     = hit | match_now;
  assign bc_f      = bcast | (dst_done & is_short & a_bc_n);

  assign second_ok = (idx != IX_FCF_LO) && (fcf_n[2:0] < TYPE_RSVD);
  assign ver_ok    = (cfg_ver_policy == 2'd3) || (fcf_n[13:12] <= cfg_ver_policy);

  assign end_fire  = second_ok & (cfg_promisc | (fcs_good & hit_f));
  assign ack_fire  = second_ok & fcs_good & hit_f & fcf_n[5] & (fcf_n[2:0] != TYPE_ACK)
                   & ~bc_f & ver_ok & ~cfg_ack_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame      <= 1'b0;
      idx           <= '0;
      fcf           <= '0;
      pan_node      <= 1'b0;
      pan_bc        <= 1'b0;
      a_node        <= 1'b0;
      a_bc          <= 1'b0;
      hit           <= 1'b0;
      bcast         <= 1'b0;
      ev_rx_start   <= 1'b0;
      ev_rx_end     <= 1'b0;
      ev_addr_match <= 1'b0;
      crc_valid     <= 1'b0;
      ack_req       <= 1'b0;
    end else begin
      ev_rx_start   <= 1'b0;
      ev_rx_end     <= 1'b0;
      ev_addr_match <= 1'b0;
      ack_req       <= 1'b0;
      if (phr_ok) begin
        in_frame    <= 1'b1;
        idx         <= '0;
        fcf         <= '0;
        pan_node    <= 1'b1;
        pan_bc      <= 1'b1;
        a_node      <= 1'b1;
        a_bc        <= 1'b1;
        hit         <= 1'b0;
        bcast       <= 1'b0;
        ev_rx_start <= 1'b1;
      end else if (take) begin
        idx   <= (idx == IX_SAT) ? idx : idx + 1'b1;
        fcf   <= fcf_n;
        hit   <= hit_f;
        bcast <= bc_f;
        if (in_pan) begin
          pan_node <= pan_node_n;
          pan_bc   <= pan_bc_n;
        end
        if (in_dst) begin
          a_node <= a_node_n;
          a_bc   <= a_bc_n;
        end
        ev_addr_match <= match_now;
        if (rx_last) begin
          in_frame  <= 1'b0;
          ev_rx_end <= end_fire;
          ack_req   <= ack_fire;
          if (end_fire) crc_valid <= fcs_good;
        end
      end
    end
  end

  AST_START_AFTER_PHR: assert property (@(posedge clk) disable iff (!rst_n)
    phr_ok |=> ev_rx_start); // R1
  AST_CRC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rx_end |-> $stable(crc_valid)); // R3
  AST_FILTER_END_GOOD_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_end && !$past(cfg_promisc)) |-> crc_valid); // R5
  AST_MATCH_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_match |-> $past(rx_valid)); // R6
  AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_match |=> !ev_addr_match); // R12
  AST_ACK_AFTER_GOOD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(rx_valid && rx_last && fcs_good)); // R8
  AST_ACK_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> ev_rx_end); // R8
  AST_ACK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> !$past(cfg_ack_off)); // R9

endmodule

// File: tb/rx_frame_filter_tb.sv
module rx_frame_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_short_addr = 16'h1234;
  logic [15:0] cfg_pan_id = 16'hCAFE;
  logic [63:0] cfg_ext_addr = 64'h0123_4567_89AB_CDEF;
  logic        cfg_promisc = 1'b0;
  logic        cfg_ack_off = 1'b0;
  logic [1:0]  cfg_ver_policy = 2'd3;
  logic        phr_ok = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        rx_valid = 1'b0;
  logic        rx_last = 1'b0;
  logic        fcs_good = 1'b0;
  logic        ev_rx_start, ev_rx_end, ev_addr_match, crc_valid, ack_req;

  rx_frame_filter u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_short_addr(cfg_short_addr), .cfg_pan_id(cfg_pan_id), .cfg_ext_addr(cfg_ext_addr),
    .cfg_promisc(cfg_promisc), .cfg_ack_off(cfg_ack_off), .cfg_ver_policy(cfg_ver_policy),
    .phr_ok(phr_ok), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_last(rx_last),
    .fcs_good(fcs_good), .ev_rx_start(ev_rx_start), .ev_rx_end(ev_rx_end),
    .ev_addr_match(ev_addr_match), .crc_valid(crc_valid), .ack_req(ack_req)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  logic [7:0] fb [0:23];
  int flen;
  int r_start, r_end, r_match, r_ack, r_midx, r_crc, r_late;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_fcf(input int typ, input bit ackr, input int dm, input int ver);
    logic [15:0] f;
    f = '0;
    f[2:0]   = 3'(typ);
    f[5]     = ackr;
    f[11:10] = 2'(dm);
    f[13:12] = 2'(ver);
    return f;
  endfunction

  task automatic build(input logic [15:0] f, input logic [15:0] pan, input logic [63:0] dst, input int pay);
    int n;
    fb[0] = f[7:0]; fb[1] = f[15:8]; fb[2] = 8'h5A;
    n = 3;
    if (f[11:10] >= 2) begin
      fb[3] = pan[7:0]; fb[4] = pan[15:8]; n = 5;
      for (int i = 0; i < ((f[11:10] == 3) ? 8 : 2); i++) begin
        fb[n] = dst[8*i +: 8]; n++;
      end
    end
    for (int i = 0; i < pay; i++) begin fb[n] = 8'(8'h30 + i); n++; end
    fb[n] = 8'hA1; fb[n+1] = 8'hB2;
    flen = n + 2;
  endtask

  task automatic sample(input int i);
    if (ev_rx_end) r_end++;
    if (ack_req) r_ack++;
    if (ev_addr_match) begin r_match++; r_midx = i; end
  endtask

  task automatic send(input bit fok);
    @(negedge clk); phr_ok = 1'b1;
    @(negedge clk); phr_ok = 1'b0;
    r_start = int'(ev_rx_start);
    r_end = 0; r_match = 0; r_ack = 0; r_midx = -1;
    for (int k = 0; k < flen; k++) begin
      if (k > 0) begin @(negedge clk); sample(k - 1); end
      rx_valid = 1'b1; rx_byte = fb[k];
      rx_last = (k == flen - 1);
      fcs_good = (k == flen - 1) && fok;
    end
    @(negedge clk); sample(flen - 1);
    rx_valid = 1'b0; rx_last = 1'b0; fcs_good = 1'b0;
    r_crc = int'(crc_valid);
    @(negedge clk);
    r_late = int'(ev_rx_end | ack_req | ev_addr_match | ev_rx_start);
  endtask

  task automatic t_reset;
    chk("R12 reset start", int'(ev_rx_start), 0);
    chk("R12 reset end", int'(ev_rx_end), 0);
    chk("R12 reset match", int'(ev_addr_match), 0);
    chk("R3 reset crc", int'(crc_valid), 0);
    chk("R12 reset ack", int'(ack_req), 0);
  endtask

  task automatic t_short_unicast;
    cfg_promisc = 0;
    build(mk_fcf(1, 1, 2, 0), 16'hCAFE, 64'h1234, 3);
    send(1);
    chk("R1 start pulse", r_start, 1);
    chk("R6 short match", r_match, 1);
    chk("R6 match after byte 6", r_midx, 6);
    chk("R5 end on good match", r_end, 1);
    chk("R3 crc set", r_crc, 1);
    chk("R8 ack unicast", r_ack, 1);
    chk("R12 single cycle", r_late, 0);
  endtask

  task automatic t_broadcast;
    build(mk_fcf(1, 1, 2, 0), 16'hCAFE, 64'hFFFF, 2);
    send(1);
    chk("R6 broadcast match", r_match, 1);
    chk("R8 no ack broadcast", r_ack, 0);
    build(mk_fcf(1, 1, 2, 0), 16'hFFFF, 64'h1234, 2);
    send(1);
    chk("R6 pan broadcast match", r_match, 1);
    chk("R8 ack pan broadcast", r_ack, 1);
    build(mk_fcf(1, 1, 2, 0), 16'hCAFF, 64'h1234, 2);
    send(1);
    chk("R6 pan mismatch", r_match, 0);
    chk("R5 no end on mismatch", r_end, 0);
  endtask

  task automatic t_ext;
    build(mk_fcf(1, 1, 3, 1), 16'hCAFE, 64'h0123_4567_89AB_CDEF, 1);
    send(1);
    chk("R6 ext match", r_match, 1);
    chk("R6 ext match after byte 12", r_midx, 12);
    chk("R8 ack ext", r_ack, 1);
    build(mk_fcf(1, 1, 3, 1), 16'hCAFE, 64'h8123_4567_89AB_CDEF, 1);
    send(1);
    chk("R6 ext top byte mismatch", r_match, 0);
    chk("R5 no end ext mismatch", r_end, 0);
    chk("R8 no ack ext mismatch", r_ack, 0);
  endtask

  task automatic t_fcs_modes;
    cfg_promisc = 0;
    build(mk_fcf(1, 1, 2, 0), 16'hCAFE, 64'h1234, 2);
    send(1);
    build(mk_fcf(1, 1, 2, 0), 16'hCAFE, 64'h1234, 2);
    send(0);
    chk("R5 no end bad fcs", r_end, 0);
    chk("R6 match despite bad fcs", r_match, 1);
    chk("R3 crc held", r_crc, 1);
    chk("R8 no ack bad fcs", r_ack, 0);
    cfg_promisc = 1;
    send(0);
    chk("R4 promisc end bad fcs", r_end, 1);
    chk("R3 crc cleared", r_crc, 0);
    build(mk_fcf(1, 0, 2, 0), 16'h0BAD, 64'h9999, 2);
    send(1);
    chk("R4 promisc end foreign", r_end, 1);
    chk("R6 promisc no match", r_match, 0);
    chk("R3 crc good again", r_crc, 1);
  endtask

  task automatic t_second_level;
    cfg_promisc = 1;
    fb[0] = 8'h01; flen = 1;
    send(1);
    chk("R2 one byte no end", r_end, 0);
    build(mk_fcf(5, 1, 2, 0), 16'hCAFE, 64'h1234, 2);
    send(1);
    chk("R2 reserved type no end", r_end, 0);
    chk("R2 reserved type no match", r_match, 0);
    chk("R2 reserved type no ack", r_ack, 0);
  endtask

  task automatic t_truncated;
    cfg_promisc = 1;
    build(mk_fcf(1, 1, 2, 0), 16'hCAFE, 64'h1234, 0);
    flen = 6;
    send(1);
    chk("R7 truncated end in promisc", r_end, 1);
    chk("R7 truncated no match", r_match, 0);
    chk("R7 truncated no ack", r_ack, 0);
    cfg_promisc = 0;
    send(1);
    chk("R7 truncated no end filtering", r_end, 0);
  endtask

  task automatic t_ack_rules;
    cfg_promisc = 0;
    build(mk_fcf(2, 1, 2, 0), 16'hCAFE, 64'h1234, 1);
    send(1);
    chk("R8 ack-type frame end", r_end, 1);
    chk("R8 no ack for ack-type", r_ack, 0);
    build(mk_fcf(1, 0, 2, 0), 16'hCAFE, 64'h1234, 1);
    send(1);
    chk("R8 no ack when not requested", r_ack, 0);
    cfg_ack_off = 1;
    build(mk_fcf(1, 1, 2, 0), 16'hCAFE, 64'h1234, 1);
    send(1);
    chk("R9 ack disabled", r_ack, 0);
    chk("R9 end still reported", r_end, 1);
    cfg_promisc = 1;
    send(1);
    chk("R9 ack disabled promisc", r_ack, 0);
    cfg_ack_off = 0;
    cfg_promisc = 0;
  endtask

  task automatic t_policy;
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 4; v++) begin
        cfg_ver_policy = 2'(p);
        build(mk_fcf(1, 1, 2, v), 16'hCAFE, 64'h1234, 1);
        send(1);
        chk($sformatf("R10 policy %0d version %0d", p, v), r_ack, (p == 3 || v <= p) ? 1 : 0);
      end
    end
    cfg_ver_policy = 2'd3;
  endtask

  task automatic t_outside;
    int e, a, m;
    e = 0; a = 0; m = 0;
    cfg_promisc = 1;
    build(mk_fcf(1, 1, 2, 0), 16'hCAFE, 64'h1234, 1);
    for (int k = 0; k < flen; k++) begin
      @(negedge clk);
      if (ev_rx_end) e++;
      if (ack_req) a++;
      if (ev_addr_match) m++;
      rx_valid = 1'b1; rx_byte = fb[k]; rx_last = (k == flen - 1); fcs_good = (k == flen - 1);
    end
    @(negedge clk);
    if (ev_rx_end) e++;
    if (ack_req) a++;
    if (ev_addr_match) m++;
    rx_valid = 1'b0; rx_last = 1'b0; fcs_good = 1'b0;
    @(negedge clk);
    chk("R11 no end outside frame", e, 0);
    chk("R11 no ack outside frame", a, 0);
    chk("R11 no match outside frame", m, 0);
    cfg_promisc = 0;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short_unicast();
    t_broadcast();
    t_ext();
    t_fcs_modes();
    t_second_level();
    t_truncated();
    t_ack_rules();
    t_policy();
    t_outside();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule